// File: doc/BRIEF.md
# Configurable Serial Receive Deframer

This block rebuilds characters from a serial line that has already been reduced to one strobe per bit period. Each strobe carries one line bit. A small state machine waits for a start bit and shifts in seven or eight data bits, least significant first. It then optionally checks a parity bit and samples one stop bit. When the stop bit arrives it hands the character to the register block, together with a parity-error flag and a framing-error flag.

The character format comes from a 3-bit format code, and the bit rate from a 2-bit divider code. Both are taken from the owning control register. One divider setting selects a slow mode in which only every fourth strobe is used. A free-running strobe counter keeps this alignment. A synchronous clear input, driven by the register block's master reset, brings the deframer back to its idle state. Holding received characters and detecting overruns are left to the register block.

Top module: `rx_deframer`

## Requirements
- R1: While waiting for a start bit, a processed strobe with line value 1 is ignored, and one with value 0 starts a character.
- R2: Data bits are assembled least significant bit first: the n-th data bit after the start bit lands in bit position n of `char_data`.
- R3: With format code bit 2 at 0 (7-bit formats 000, 001, 010, 011), seven data bits are taken, a parity bit always follows them, and `char_data[7]` is 0.
- R4: With format code bit 2 at 1 (8-bit formats), a parity bit follows the eight data bits only when format code bit 1 is 1. Codes 100 and 101 go straight from data to stop.
- R5: Parity counts the ones among the data bits and the parity bit. `par_err` is 1 when that count's oddness (1 = odd) differs from format code bit 0, so bit 0 = 0 selects even parity and bit 0 = 1 selects odd parity.
- R6: Exactly one stop bit is sampled, even in two-stop formats. A 0 stop bit sets `frm_err`. After the stop bit the block is back waiting for a start bit, with its bit count, shift register and parity state cleared, so a further 1 bit is treated as idle.
- R7: `char_vld` is high for exactly one cycle, in the cycle after the clock edge that takes the stop strobe. `char_data`, `par_err` and `frm_err` take the new character's values in that same cycle and hold them until the next handoff or clear.
- R8: A 2-bit strobe counter, cleared to 0, advances on every strobe whatever the divider code. With `rate_sel` = 2'b10, a strobe is processed only when it wraps the counter to 0. Any other code processes every strobe.
- R9: `soft_clr` returns the block to waiting for a start bit. It clears the strobe counter, the shift register, `char_data`, `par_err` and `frm_err`. It also wins over a strobe in the same cycle, so a stop strobe that arrives with it delivers no character.
- R10: A cycle without a processed strobe leaves the receive state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| soft_clr | input | 1 | Synchronous clear from the master-reset decode |
| bit_stb | input | 1 | One-cycle strobe: `bit_val` holds one line bit |
| bit_val | input | 1 | Sampled line level |
| fmt_code | input | 3 | Character format code (length, parity enable, parity sense) |
| rate_sel | input | 2 | Divider code; 2'b10 selects the quarter-rate mode |
| char_vld | output | 1 | One-cycle pulse: a character was handed off |
| char_data | output | 8 | Last handed-off character |
| par_err | output | 1 | Parity error of the last character |
| frm_err | output | 1 | Framing error (stop bit 0) of the last character |

## Verification
Two functions can meet in one cycle: the synchronous clear and the stop strobe that would hand off a character. The bench drives a complete frame up to its stop bit and then raises `soft_clr` on the same edge as that stop strobe. A correct result has no `char_vld` pulse, zeroed data and flags, and a clean character on the next frame. A second collision is the strobe counter advancing in full-rate mode just before the slow mode is chosen. It is judged by whether the correct later strobe is taken as the start bit.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_PAR  = 2'd2,
    ST_STOP = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic odd;
  } fmt_t;

  localparam int FMT_W = 3;

endpackage

// File: rtl/rxdf_rst_sync.sv
module rxdf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rxdf_fmt_decode.sv
module rxdf_fmt_decode
  import rxdf_pkg::*;
(
  input  logic [FMT_W-1:0] fmt_code,
  output fmt_t             fmt
);

  always_comb begin
    fmt.eight  = fmt_code[2];
    fmt.par_en = ~fmt_code[2] | fmt_code[1];
    fmt.odd    = fmt_code[0];
  end

endmodule

// File: rtl/rxdf_strobe_gate.sv
module rxdf_strobe_gate #(
  parameter int             CNT_W     = 2,
  parameter int             DIV_W     = 2,
  parameter logic [DIV_W-1:0] SLOW_CODE = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             bit_stb,
  input  logic [DIV_W-1:0] rate_sel,
  output logic             go
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             slow_mode;

  always_comb begin
    cnt_en    = soft_clr | bit_stb;
    cnt_d     = soft_clr ? '0 : cnt_q + CNT_W'(1);
    slow_mode = (rate_sel == SLOW_CODE);
    go        = bit_stb & ~soft_clr & (~slow_mode | (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (cnt_q == '0)); // R9

  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !soft_clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R8

endmodule

// File: rtl/rxdf_assembler.sv
module rxdf_assembler #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              par_stb,
  input  logic              bit_val,
  input  logic              odd,
  output logic [DATA_W-1:0] shreg,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              perr
);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              acc_q, acc_d;
  logic              perr_q, perr_d;
  logic              upd_en;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      if (clear) begin
        shreg_d[i] = 1'b0;
      end else if (shift_en && (cnt_q == CNT_W'(i))) begin
        shreg_d[i] = bit_val;
      end else begin
        shreg_d[i] = shreg_q[i];
      end
    end
  end

  always_comb begin
    upd_en = clear | shift_en | par_stb;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    perr_d = perr_q;
    if (clear) begin
      cnt_d  = '0;
      acc_d  = 1'b0;
      perr_d = 1'b0;
    end else if (shift_en) begin
      cnt_d = cnt_q + CNT_W'(1);
      acc_d = acc_q ^ bit_val;
    end else if (par_stb) begin
      acc_d  = acc_q ^ bit_val;
      perr_d = (acc_q ^ bit_val) != odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else if (upd_en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
    end
  end

  assign shreg   = shreg_q;
  assign bit_cnt = cnt_q;
  assign perr    = perr_q;

  AST_ACC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0 && !perr_q && !acc_q && shreg_q == '0)); // R6

endmodule

// File: rtl/rxdf_fsm.sv
module rxdf_fsm
  import rxdf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             go,
  input  logic             bit_val,
  input  fmt_t             fmt,
  input  logic [CNT_W-1:0] bit_cnt,
  output rx_state_e        state,
  output logic             shift_en,
  output logic             par_stb,
  output logic             done
);

  rx_state_e state_q, state_d;
  logic      last_bit;

  always_comb begin
    last_bit = fmt.eight ? (bit_cnt == CNT_W'(DATA_W - 1))
                         : (bit_cnt == CNT_W'(DATA_W - 2));
    state_d  = state_q;
    shift_en = 1'b0;
    par_stb  = 1'b0;
    done     = 1'b0;
    if (soft_clr) begin
      state_d = ST_HUNT;
    end else if (go) begin
      unique case (state_q)
        ST_HUNT: begin
          if (!bit_val) state_d = ST_DATA;
        end
        ST_DATA: begin
          shift_en = 1'b1;
          if (last_bit) state_d = fmt.par_en ? ST_PAR : ST_STOP;
        end
        ST_PAR: begin
          par_stb = 1'b1;
          state_d = ST_STOP;
        end
        ST_STOP: begin
          done    = 1'b1;
          state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && go && bit_val && !soft_clr) |=> (state_q == ST_HUNT)); // R1

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !soft_clr) |=> $stable(state_q)); // R10

  AST_CLEAR_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (state_q == ST_HUNT)); // R9

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({shift_en, par_stb, done}) <= 1); // R6

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rxdf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 2,
  parameter int SKIP_W = 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [FMT_W-1:0]  fmt_code,
  input  logic [DIV_W-1:0]  rate_sel,
  output logic              char_vld,
  output logic [DATA_W-1:0] char_data,
  output logic              par_err,
  output logic              frm_err
);

  logic              rst_ns;
  fmt_t              fmt;
  logic              go;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              perr;
  rx_state_e         state;
  logic              shift_en;
  logic              par_stb;
  logic              done;
  logic              asm_clear;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              out_en;

  rxdf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  rxdf_fmt_decode u_fmt (
    .fmt_code (fmt_code),
    .fmt      (fmt)
  );

  rxdf_strobe_gate #(
    .CNT_W     (SKIP_W),
    .DIV_W     (DIV_W),
    .SLOW_CODE (DIV_W'(2))
  ) u_gate (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_clr (soft_clr),
    .bit_stb  (bit_stb),
    .rate_sel (rate_sel),
    .go       (go)
  );

  rxdf_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .soft_clr (soft_clr),
    .go       (go),
    .bit_val  (bit_val),
    .fmt      (fmt),
    .bit_cnt  (bit_cnt),
    .state    (state),
    .shift_en (shift_en),
    .par_stb  (par_stb),
    .done     (done)
  );

  assign asm_clear = soft_clr | done;

  rxdf_assembler #(.DATA_W(DATA_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_ns),
    .clear    (asm_clear),
    .shift_en (shift_en),
    .par_stb  (par_stb),
    .bit_val  (bit_val),
    .odd      (fmt.odd),
    .shreg    (shreg),
    .bit_cnt  (bit_cnt),
    .perr     (perr)
  );

  always_comb begin
    out_en = soft_clr | done;
    vld_d  = done & ~soft_clr;
    data_d = data_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (soft_clr) begin
      data_d = '0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
    end else if (done) begin
      data_d = shreg;
      perr_d = perr;
      ferr_d = ~bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      data_q <= '0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else if (out_en) begin
      data_q <= data_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign char_vld  = vld_q;
  assign char_data = data_q;
  assign par_err   = perr_q;
  assign frm_err   = ferr_q;

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_ns)
    char_vld |=> !char_vld); // R7

  AST_HANDOFF_IDLE: assert property (@(posedge clk) disable iff (!rst_ns)
    char_vld |-> (state == ST_HUNT)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!done && !soft_clr) |=> ($stable(char_data) && $stable(par_err) && $stable(frm_err))); // R7

  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_ns)
    soft_clr |=> (!char_vld && char_data == '0 && !par_err && !frm_err)); // R9

endmodule

// File: tb/tb_rx_deframer.sv
module tb_rx_deframer;

  logic       clk;
  logic       rst_n;
  logic       soft_clr;
  logic       bit_stb;
  logic       bit_val;
  logic [2:0] fmt_code;
  logic [1:0] rate_sel;
  logic       char_vld;
  logic [7:0] char_data;
  logic       par_err;
  logic       frm_err;

  int checks;
  int fails;
  bit finished;

  rx_deframer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .fmt_code  (fmt_code),
    .rate_sel  (rate_sel),
    .char_vld  (char_vld),
    .char_data (char_data),
    .par_err   (par_err),
    .frm_err   (frm_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_bit(input logic v);
    @(negedge clk);
    bit_stb = 1'b1;
    bit_val = v;
    @(negedge clk);
    bit_stb = 1'b0;
    bit_val = 1'b1;
  endtask

  task automatic do_slow_bit(input logic v);
    for (int k = 0; k < 3; k++) do_bit(~v);
    do_bit(v);
  endtask

  task automatic send_body(input logic [7:0] d, input bit bad_par);
    logic eight;
    logic pen;
    logic pbit;
    int   n;
    eight = fmt_code[2];
    pen   = ~fmt_code[2] | fmt_code[1];
    n     = eight ? 8 : 7;
    do_bit(1'b0);
    pbit = fmt_code[0];
    for (int i = 0; i < n; i++) begin
      do_bit(d[i]);
      pbit ^= d[i];
    end
    if (pen) do_bit(pbit ^ bad_par);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop_v);
    send_body(d, bad_par);
    do_bit(stop_v);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input logic pe, input logic fe);
    chk({req, " vld"}, char_vld, 1'b1);
    chk({req, " data"}, char_data, d);
    chk({req, " par_err"}, par_err, pe);
    chk({req, " frm_err"}, frm_err, fe);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9 reset vld", char_vld, 1'b0);
    chk("R9 reset data", char_data, 8'h00);
    chk("R9 reset flags", {par_err, frm_err}, 2'b00);
  endtask

  task automatic t_idle_and_8n1();
    fmt_code = 3'b101;
    rate_sel = 2'b01;
    for (int i = 0; i < 5; i++) begin
      do_bit(1'b1);
      chk("R1 idle one ignored", char_vld, 1'b0);
    end
    send_frame(8'hA5, 1'b0, 1'b1);
    expect_char("R1 R4 8N1 A5", 8'hA5, 1'b0, 1'b0);
  endtask

  task automatic t_lsb_first();
    fmt_code = 3'b100;
    send_frame(8'h01, 1'b0, 1'b1);
    expect_char("R2 lsb 01", 8'h01, 1'b0, 1'b0);
    do_bit(1'b1);
    send_frame(8'h80, 1'b0, 1'b1);
    expect_char("R2 msb 80", 8'h80, 1'b0, 1'b0);
  endtask

  task automatic t_8bit_parity();
    fmt_code = 3'b110;
    send_frame(8'h3C, 1'b0, 1'b1);
    expect_char("R4 R5 8E1 good", 8'h3C, 1'b0, 1'b0);
    send_frame(8'h3D, 1'b1, 1'b1);
    expect_char("R5 8E1 bad", 8'h3D, 1'b1, 1'b0);
    fmt_code = 3'b111;
    send_frame(8'h3C, 1'b0, 1'b1);
    expect_char("R5 8O1 good", 8'h3C, 1'b0, 1'b0);
    send_frame(8'hF7, 1'b1, 1'b1);
    expect_char("R5 8O1 bad", 8'hF7, 1'b1, 1'b0);
  endtask

  task automatic t_7bit();
    fmt_code = 3'b010;
    send_frame(8'hD5, 1'b0, 1'b1);
    expect_char("R3 7E1 msb zero", 8'h55, 1'b0, 1'b0);
    fmt_code = 3'b011;
    send_frame(8'h13, 1'b1, 1'b1);
    expect_char("R3 R5 7O1 bad", 8'h13, 1'b1, 1'b0);
    fmt_code = 3'b001;
    send_frame(8'h6E, 1'b0, 1'b1);
    expect_char("R3 7O2 first", 8'h6E, 1'b0, 1'b0);
    do_bit(1'b1);
    chk("R6 second stop idle", char_vld, 1'b0);
    send_frame(8'h2A, 1'b0, 1'b1);
    expect_char("R6 7O2 next", 8'h2A, 1'b0, 1'b0);
  endtask

  task automatic t_framing_and_hold();
    fmt_code = 3'b101;
    send_frame(8'h5A, 1'b0, 1'b0);
    expect_char("R6 bad stop", 8'h5A, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 pulse one cycle", char_vld, 1'b0);
    for (int i = 0; i < 3; i++) do_bit(1'b1);
    chk("R7 data held", char_data, 8'h5A);
    chk("R7 flag held", frm_err, 1'b1);
    send_frame(8'hC3, 1'b0, 1'b1);
    expect_char("R7 flags renewed", 8'hC3, 1'b0, 1'b0);
  endtask

  task automatic t_slow_mode();
    pulse_clear();
    fmt_code = 3'b110;
    rate_sel = 2'b10;
    begin
      logic p;
      p = 1'b0;
      do_slow_bit(1'b0);
      for (int i = 0; i < 8; i++) begin
        do_slow_bit(8'h96 >> i);
        p ^= 1'((8'h96 >> i) & 8'h01);
      end
      do_slow_bit(p);
      for (int k = 0; k < 3; k++) begin
        do_bit(1'b0);
        chk("R8 skipped strobe", char_vld, 1'b0);
      end
      do_bit(1'b1);
    end
    expect_char("R8 slow char", 8'h96, 1'b0, 1'b0);
    pulse_clear();
    rate_sel = 2'b01;
    fmt_code = 3'b101;
    do_bit(1'b1);
    do_bit(1'b1);
    rate_sel = 2'b10;
    do_bit(1'b0);
    do_bit(1'b0);
    for (int i = 0; i < 8; i++) do_slow_bit(8'h4B >> i);
    do_slow_bit(1'b1);
    expect_char("R8 counter runs at full rate", 8'h4B, 1'b0, 1'b0);
    rate_sel = 2'b01;
  endtask

  task automatic t_soft_clear();
    fmt_code = 3'b101;
    send_frame(8'hE1, 1'b0, 1'b0);
    expect_char("R9 before clear", 8'hE1, 1'b0, 1'b1);
    do_bit(1'b0);
    do_bit(1'b0);
    do_bit(1'b1);
    pulse_clear();
    chk("R9 clear data", char_data, 8'h00);
    chk("R9 clear flags", {par_err, frm_err}, 2'b00);
    send_frame(8'h77, 1'b0, 1'b1);
    expect_char("R9 after clear", 8'h77, 1'b0, 1'b0);
    send_body(8'h99, 1'b0);
    @(negedge clk);
    bit_stb  = 1'b1;
    bit_val  = 1'b1;
    soft_clr = 1'b1;
    @(negedge clk);
    bit_stb  = 1'b0;
    soft_clr = 1'b0;
    chk("R9 clear wins vld", char_vld, 1'b0);
    chk("R9 clear wins data", char_data, 8'h00);
    do_bit(1'b1);
    chk("R10 R9 stays idle", char_vld, 1'b0);
    send_frame(8'h18, 1'b0, 1'b1);
    expect_char("R9 clean after collision", 8'h18, 1'b0, 1'b0);
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    finished = 0;
    rst_n    = 1'b0;
    soft_clr = 1'b0;
    bit_stb  = 1'b0;
    bit_val  = 1'b1;
    fmt_code = 3'b101;
    rate_sel = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_idle_and_8n1();
    t_lsb_first();
    t_8bit_parity();
    t_7bit();
    t_framing_and_hold();
    t_slow_mode();
    t_soft_clear();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule